// File: doc/BRIEF.md
# Strobe-Latched 256x4 Static Memory

This block is a 256-word by 4-bit static memory whose address is captured when a chip-enable strobe falls, not used as a live input. All inputs are synchronous to a system clock, and the block detects the strobe's high-to-low transition by sampling it on that clock. From that edge until the strobe goes high again, the captured address alone selects the word. A 5-bit row field and a 3-bit group field drive two gated one-hot decoders into a 32 by 32 cell matrix.

A write-enable and two select lines pick the operation. A write stores the input bus at the captured address. A read loads a data latch that keeps driving the data output after the strobe rises. The shared data bus is split at the edge into an input bus, an output bus and an output-enable. A board-level tri-state buffer joins them into one wire. When the output-enable is low the bus is released (high impedance), so several memories can share one bus.

Top module: `strobe_sram`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0 and `dq_out` is 0. Stored contents are not cleared by reset.
- R2: The memory holds 256 independent 4-bit words. The row is `addr[7:3]` and the 4-bit group within the row is `addr[2:0]`. Writing a word and reading it back later returns that word, with all other words unchanged.
- R3: `addr` is captured at the first rising clock edge that samples `ce_n` low after it was sampled high. Later changes on `addr` while `ce_n` stays low do not affect that cycle.
- R4: From the second edge of an active strobe period onward, each edge that samples `ce_n`, `we_n` and `s1_n` all low stores `dq_in` at the captured address.
- R5: A write attempted with `s1_n` high leaves memory unchanged. `s2_n` does not gate writes.
- R6: `dq_oe` is 1 only when all of these hold: `ce_n`, `s1_n` and `s2_n` are low, `we_n` is high, and the read latch was loaded at the previous edge. It is 0 during writes, and it drops in the same cycle that any of these inputs leaves its active level.
- R7: With `we_n` high, `dq_out` shows the word at the captured address one edge after capture. It is refreshed on every further edge while the strobe stays low.
- R8: While `ce_n` is sampled high, `dq_out` holds the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip-enable strobe, active low; its falling edge captures the address |
| we_n | input | 1 | Write enable, active low |
| s1_n | input | 1 | Select 1, active low; gates writes and the output |
| s2_n | input | 1 | Select 2, active low; gates the output only |
| addr | input | 8 | Word address, row in bits 7:3, group in bits 2:0 |
| dq_in | input | 4 | Input half of the shared data bus |
| dq_out | output | 4 | Output half of the shared data bus, driven from the read latch |
| dq_oe | output | 1 | Bus drive enable; 0 means the bus is released |

## Verification
The hardest case is showing that the address used is the captured one and not the live one. A design that reads `addr` directly returns correct data whenever the address is held steady. So every read in the bench changes `addr` to its complement right after the capture edge. One extra test also holds the strobe low for several edges while moving the address each cycle, and checks that the data never follows it. Writes go through the same address scrambling, so a write that lands on the live address leaves a mismatched word for the read-back pass to find.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;

  localparam int DEF_ROW_W  = 5;
  localparam int DEF_COL_W  = 3;
  localparam int DEF_WORD_W = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

endpackage

// File: rtl/strobe_sram_capture.sv
module strobe_sram_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_act,
  output logic [ADDR_W-1:0] lat_addr
);

  logic              ce_prev_q;
  logic              strobe_fall;
  logic              act_d;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d;

  assign strobe_fall = ce_prev_q & ~ce_n;

  always_comb begin
    act_d   = cyc_act;
    addr_en = 1'b0;
    addr_d  = lat_addr;
    if (strobe_fall) begin
      act_d   = 1'b1;
      addr_en = 1'b1;
      addr_d  = addr;
    end else if (ce_n) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q <= 1'b1;
      cyc_act   <= 1'b0;
    end else begin
      ce_prev_q <= ce_n;
      cyc_act   <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
    end else if (addr_en) begin
      lat_addr <= addr_d;
    end
  end

endmodule

// File: rtl/strobe_sram_decode.sv
module strobe_sram_decode #(
  parameter int SEL_W = 5
) (
  input  logic                  gate,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] onehot
);

  localparam int LINES = 1 << SEL_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign onehot[i] = gate & (sel == SEL_W'(i));
  end

endmodule

// File: rtl/strobe_sram_array.sv
module strobe_sram_array #(
  parameter int ROWS   = 32,
  parameter int GROUPS = 8,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [GROUPS-1:0] col_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int COLS = GROUPS * WORD_W;

  logic [COLS-1:0] row_bus [ROWS];
  logic [COLS-1:0] row_word;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic            row_we;
    logic [COLS-1:0] row_d;
    logic [COLS-1:0] row_q;

    assign row_we = wr_en & row_sel[r];

    always_comb begin
      row_d = row_q;
      for (int g = 0; g < GROUPS; g++) begin
        if (col_sel[g]) begin
          row_d[g*WORD_W +: WORD_W] = wdata;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (row_we) begin
        row_q <= row_d;
      end
    end

    assign row_bus[r] = row_q;
  end

  always_comb begin
    row_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      row_word = row_word | (row_bus[r] & {COLS{row_sel[r]}});
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      rdata = rdata | (row_word[g*WORD_W +: WORD_W] & {WORD_W{col_sel[g]}});
    end
  end

endmodule

// File: rtl/strobe_sram.sv
module strobe_sram
  import strobe_sram_pkg::*;
#(
  parameter int ROW_W  = DEF_ROW_W,
  parameter int COL_W  = DEF_COL_W,
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   s1_n,
  input  logic                   s2_n,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [WORD_W-1:0]      dq_in,
  output logic [WORD_W-1:0]      dq_out,
  output logic                   dq_oe
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int GROUPS = 1 << COL_W;

  logic              cyc_act;
  logic [ADDR_W-1:0] lat_addr;
  logic [ROWS-1:0]   row_sel;
  logic [GROUPS-1:0] col_sel;
  logic [WORD_W-1:0] arr_rdata;
  sram_op_e          op;
  logic              wr_en;
  logic              rd_load;
  logic [WORD_W-1:0] rd_q;
  logic              rd_valid;

  strobe_sram_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .addr     (addr),
    .cyc_act  (cyc_act),
    .lat_addr (lat_addr)
  );

  strobe_sram_decode #(.SEL_W(ROW_W)) u_row_dec (
    .gate   (cyc_act),
    .sel    (lat_addr[ADDR_W-1:COL_W]),
    .onehot (row_sel)
  );

  strobe_sram_decode #(.SEL_W(COL_W)) u_col_dec (
    .gate   (cyc_act),
    .sel    (lat_addr[COL_W-1:0]),
    .onehot (col_sel)
  );

  strobe_sram_array #(
    .ROWS   (ROWS),
    .GROUPS (GROUPS),
    .WORD_W (WORD_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .row_sel (row_sel),
    .col_sel (col_sel),
    .wdata   (dq_in),
    .rdata   (arr_rdata)
  );

  always_comb begin
    op = OP_IDLE;
    if (cyc_act && !ce_n) begin
      if (we_n) begin
        op = OP_READ;
      end else if (!s1_n) begin
        op = OP_WRITE;
      end
    end
  end

  assign wr_en   = (op == OP_WRITE);
  assign rd_load = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load) begin
      rd_q <= arr_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_load;
    end
  end

  assign dq_out = rd_q;
  assign dq_oe  = rd_valid & ~ce_n & we_n & ~s1_n & ~s2_n;

endmodule

// File: rtl/strobe_sram_chk.sv
module strobe_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int ROWS   = 32,
  parameter int GROUPS = 8,
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              s1_n,
  input logic              s2_n,
  input logic              dq_oe,
  input logic [WORD_W-1:0] dq_out,
  input logic              cyc_act,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [ROWS-1:0]   row_sel,
  input logic [GROUPS-1:0] col_sel
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (cyc_act && $past(cyc_act)) |-> $stable(lat_addr));

  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_act |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1));

  assert_decode_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_act |-> ($onehot0(row_sel) && row_sel == '0 && col_sel == '0));

  assert_hiz_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);

  assert_drive_after_edge_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    dq_oe |-> (!ce_n && $past(!ce_n) && !s1_n && !s2_n));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    $past(ce_n) |-> $stable(dq_out));

endmodule

bind strobe_sram strobe_sram_chk #(
  .ADDR_W (ADDR_W),
  .ROWS   (ROWS),
  .GROUPS (GROUPS),
  .WORD_W (WORD_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .s1_n     (s1_n),
  .s2_n     (s2_n),
  .dq_oe    (dq_oe),
  .dq_out   (dq_out),
  .cyc_act  (cyc_act),
  .lat_addr (lat_addr),
  .row_sel  (row_sel),
  .col_sel  (col_sel)
);

// File: tb/strobe_sram_tb_top.sv
module strobe_sram_tb_top;

  logic       clk;
  logic       rst_n;
  logic       ce_n;
  logic       we_n;
  logic       s1_n;
  logic       s2_n;
  logic [7:0] addr;
  logic [3:0] dq_in;
  logic [3:0] dq_out;
  logic       dq_oe;

  int n_chk;
  int n_err;
  int cycles;
  logic [3:0] model [256];

  strobe_sram dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .s1_n   (s1_n),
    .s2_n   (s2_n),
    .addr   (addr),
    .dq_in  (dq_in),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  function automatic logic [3:0] pat(input logic [7:0] a);
    return a[3:0] ^ a[7:4] ^ 4'hA;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe period: capture, one active edge, release
  task automatic access(input logic [7:0] a, input logic wr, input logic s1, input logic s2,
                        input logic [3:0] din, output logic [3:0] q,
                        output logic oe_early, output logic oe_mid, output logic oe_after);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = ~wr; s1_n = s1; s2_n = s2; dq_in = din;
    @(negedge clk);
    oe_early = dq_oe;
    addr = ~a;
    @(negedge clk);
    q = dq_out;
    oe_mid = dq_oe;
    ce_n = 1'b1; we_n = 1'b1;
    #1 oe_after = dq_oe;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 oe in reset", {3'b0, dq_oe}, 4'h0);
    check("R1 dq_out in reset", dq_out, 4'h0);
  endtask

  task automatic t_fill;
    logic [3:0] q;
    logic e0, e1, e2;
    for (int a = 0; a < 256; a++) begin
      model[a] = pat(8'(a));
      access(8'(a), 1'b1, 1'b0, 1'b0, model[a], q, e0, e1, e2);
      check("R6 hi-z during write", {3'b0, e0 | e1}, 4'h0);
    end
  endtask

  task automatic t_readall;
    logic [3:0] q;
    logic e0, e1, e2;
    for (int a = 0; a < 256; a++) begin
      access(8'(a), 1'b0, 1'b0, 1'b0, 4'h0, q, e0, e1, e2);
      check("R2 R3 R7 read data", q, model[a]);
      check("R6 drive on read", {3'b0, e1}, 4'h1);
      if (a < 8) begin
        check("R6 release on strobe high", {3'b0, e2}, 4'h0);
        check("R6 no drive before load", {3'b0, e0}, 4'h0);
      end
    end
  endtask

  task automatic t_hold;
    logic [3:0] q;
    logic e0, e1, e2;
    access(8'h37, 1'b0, 1'b0, 1'b0, 4'h0, q, e0, e1, e2);
    for (int i = 0; i < 4; i++) begin
      addr = 8'(i * 13);
      @(negedge clk);
      check("R8 output held while idle", dq_out, model[8'h37]);
      check("R6 released while idle", {3'b0, dq_oe}, 4'h0);
    end
  endtask

  task automatic t_long_strobe;
    @(negedge clk);
    addr = 8'hC4; ce_n = 1'b0; we_n = 1'b1; s1_n = 1'b0; s2_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      addr = 8'(8'hC4 + 8'(i) + 8'd1);
      if (i > 0) check("R3 R7 captured address kept", dq_out, model[8'hC4]);
    end
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_selects;
    logic [3:0] q;
    logic e0, e1, e2;
    access(8'h10, 1'b0, 1'b1, 1'b0, 4'h0, q, e0, e1, e2);
    check("R6 s1 high releases", {3'b0, e1}, 4'h0);
    access(8'h11, 1'b0, 1'b0, 1'b1, 4'h0, q, e0, e1, e2);
    check("R6 s2 high releases", {3'b0, e1}, 4'h0);
    check("R7 latch still loads with s2 high", q, model[8'h11]);
  endtask

  task automatic t_s1_block;
    logic [3:0] q;
    logic e0, e1, e2;
    access(8'h05, 1'b1, 1'b1, 1'b0, ~model[8'h05], q, e0, e1, e2);
    access(8'h05, 1'b0, 1'b0, 1'b0, 4'h0, q, e0, e1, e2);
    check("R5 write blocked by s1", q, model[8'h05]);
  endtask

  task automatic t_s2_write;
    logic [3:0] q;
    logic e0, e1, e2;
    model[8'hE6] = ~model[8'hE6];
    access(8'hE6, 1'b1, 1'b0, 1'b1, model[8'hE6], q, e0, e1, e2);
    access(8'hE6, 1'b0, 1'b0, 1'b0, 4'h0, q, e0, e1, e2);
    check("R4 R5 write with s2 high", q, model[8'hE6]);
    access(8'hE7, 1'b0, 1'b0, 1'b0, 4'h0, q, e0, e1, e2);
    check("R2 neighbour untouched", q, model[8'hE7]);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; s1_n = 1'b0; s2_n = 1'b0;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fill();
    t_readall();
    t_hold();
    t_long_strobe();
    t_selects();
    t_s1_block();
    t_s2_write();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule